// File: doc/BRIEF.md
# Clock Synthesizer Serial Programmer

This block loads a new multiplier and divider setting into an external frequency-synthesizer chip through a three-wire serial path. The three wires are a gated serial clock, a data line and a load strobe. A single-cycle request carries three fields: a 9-bit feedback multiplier, a 2-bit output divider and a 2-bit test field. The block packs them into a 14-bit frame and shifts the frame out most-significant bit first. It then pulses the load strobe so the chip moves its shift register into its active configuration. A fourth output, the parallel-load select, is held low so the chip always stays in serial mode.

The serial clock comes from the system clock through a divider. Each half period of the serial clock lasts `HALF_DIV` system clocks. The serial clock runs only while frame bits are moving. The data line changes only on the falling edge of the serial clock, so the chip, which samples on the rising edge, sees stable data. `busy_o` covers the whole transfer. `done_o` marks its end.

Top module: `synth_serial_loader`

## Requirements
- R1: `pload_o` is 0 in every cycle, including during and after reset.
- R2: Each transfer shifts exactly 14 bits in this order: test[1], test[0], a constant 0, div[1], div[0], then mult[8] down to mult[0]. The first bit is on `sdata_o` before the first rising edge of `sclk_o`.
- R3: `sdata_o` never changes while `sclk_o` is high, and it never changes in the same cycle that `sclk_o` rises.
- R4: `sclk_o` is low whenever `busy_o` is low. It makes exactly 14 rising edges per transfer and stays low while the strobe is high.
- R5: Consecutive rising edges of `sclk_o` in one transfer are exactly 2*HALF_DIV system clocks apart.
- R6: `strobe_o` is low while bits are shifting. It rises after the last falling edge of `sclk_o` and stays high for exactly 2*HALF_DIV system clocks, which is one serial-clock period.
- R7: `done_o` is high for exactly one system clock, starting one clock after `strobe_o` falls. `busy_o` is low in that cycle.
- R8: A request that arrives while `busy_o` is high is ignored. The frame in progress completes unchanged and no second frame follows.
- R9: After reset, `sclk_o`, `strobe_o`, `busy_o` and `done_o` are 0. `busy_o` rises in the clock after an accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Start a transfer (accepted only when idle) |
| mult_i | input | 9 | Feedback multiplier field |
| div_i | input | 2 | Output divider field |
| test_i | input | 2 | Test field (00 for normal use) |
| sclk_o | output | 1 | Gated serial clock to the synthesizer |
| sdata_o | output | 1 | Serial data to the synthesizer |
| strobe_o | output | 1 | Load strobe that latches the shifted frame |
| pload_o | output | 1 | Parallel-load select, held low |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The embedded assertions check the timing rules on every cycle: the serial clock is quiet whenever the block is idle, the data line holds still at each rising serial edge, the strobe and the serial clock are never high together, a done pulse follows each strobe fall, and the bit counter never moves backwards in the middle of a frame. Some properties can only be shown by the bench's scenarios. These are the bit content and order of whole frames, captured by a model of the chip's shift register and compared against a scoreboard. They also include the exact serial-clock period and strobe width, the count of 14 rising edges, and the rejection of requests issued mid-transfer.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int M_W     = 9;
  localparam int N_W     = 2;
  localparam int T_W     = 2;
  localparam int FRAME_W = T_W + 1 + N_W + M_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SHIFT  = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } prog_state_t;

  // Frame word, MSB is sent first: test, null bit, divider, multiplier.
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [T_W-1:0] t,
    input logic [N_W-1:0] n,
    input logic [M_W-1:0] m
  );
    return {t, 1'b0, n, m};
  endfunction
endpackage

// File: rtl/sprog_tick_gen.sv
module sprog_tick_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sprog_shifter.sv
module sprog_shifter #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sreg_q;

  assign msb_o = sreg_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg_q <= '0;
    else if (load_i)  sreg_q <= data_i;
    else if (shift_i) sreg_q <= {sreg_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import synth_prog_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic [M_W-1:0] mult_i,
  input  logic [N_W-1:0] div_i,
  input  logic [T_W-1:0] test_i,
  output logic           sclk_o,
  output logic           sdata_o,
  output logic           strobe_o,
  output logic           pload_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam int BCW = $clog2(FRAME_W);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_W - 1);

  prog_state_t   state_q;
  logic          sclk_q, strobe_q, done_q, strobe_half_q;
  logic [BCW-1:0] bit_cnt_q;

  // Named internal events
  logic tick, accept, rise_evt, fall_evt, last_bit, frame_end;

  assign accept    = req_i && (state_q == ST_IDLE);
  assign rise_evt  = (state_q == ST_SHIFT) && tick && !sclk_q;
  assign fall_evt  = (state_q == ST_SHIFT) && tick && sclk_q;
  assign last_bit  = (bit_cnt_q == LAST_BIT);
  assign frame_end = fall_evt && last_bit;

  sprog_tick_gen #(.HALF_DIV(HALF_DIV)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  ((state_q == ST_SHIFT) || (state_q == ST_STROBE)),
    .tick_o(tick)
  );

  sprog_shifter #(.W(FRAME_W)) shift_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .shift_i(fall_evt && !last_bit),
    .data_i (pack_frame(test_i, div_i, mult_i)),
    .msb_o  (sdata_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      sclk_q        <= 1'b0;
      strobe_q      <= 1'b0;
      done_q        <= 1'b0;
      strobe_half_q <= 1'b0;
      bit_cnt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_SHIFT;
          bit_cnt_q <= '0;
          sclk_q    <= 1'b0;
        end
        ST_SHIFT: begin
          if (rise_evt) sclk_q <= 1'b1;
          if (fall_evt) begin
            sclk_q <= 1'b0;
            if (last_bit) begin
              state_q       <= ST_STROBE;
              strobe_q      <= 1'b1;
              strobe_half_q <= 1'b0;
            end else begin
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end
        end
        ST_STROBE: if (tick) begin
          if (strobe_half_q) begin
            strobe_q <= 1'b0;
            state_q  <= ST_DONE;
          end else begin
            strobe_half_q <= 1'b1;
          end
        end
        ST_DONE: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sclk_o   = sclk_q;
  assign strobe_o = strobe_q;
  assign done_o   = done_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign pload_o  = 1'b0;

  AST_SCLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_q); // R4
  AST_DATA_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(sdata_o)); // R3
  AST_STROBE_SCLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |-> !sclk_q); // R6
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_q) |=> (done_q && !busy_o)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHIFT) |=> (bit_cnt_q >= $past(bit_cnt_q))); // R8
  AST_FRAME_END_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (strobe_q && (state_q == ST_STROBE))); // R6
endmodule

// File: tb/synth_serial_loader_tb.sv
module synth_serial_loader_tb_top;
  localparam int HD = 4;
  localparam int FW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0;
  logic [8:0] mult = '0;
  logic [1:0] div = '0;
  logic [1:0] test = '0;
  logic sclk, sdata, strobe, pload, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  synth_serial_loader #(.HALF_DIV(HD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mult_i(mult), .div_i(div),
    .test_i(test), .sclk_o(sclk), .sdata_o(sdata), .strobe_o(strobe),
    .pload_o(pload), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard queue of expected frames, built bit by bit from the field order.
  logic [FW-1:0] exp_q[$];
  int frames_done = 0;

  function automatic logic [FW-1:0] expect_frame(logic [1:0] t, logic [1:0] n, logic [8:0] m);
    logic [FW-1:0] f;
    f[13] = t[1]; f[12] = t[0]; f[11] = 1'b0; f[10] = n[1]; f[9] = n[0];
    for (int i = 0; i < 9; i++) f[i] = m[i];
    return f;
  endfunction

  // Monitor: chip model plus timing checks, sampled on the falling system edge.
  logic [FW-1:0] dev_sreg = '0;
  int rises = 0, last_rise = -1, strobe_rise = 0, strobe_fall = -10;
  logic p_sclk = 0, p_strobe = 0, p_sdata = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pload) chk(1'b0, "R1 pload", pload, 0);
      if (sclk && p_sclk && (sdata != p_sdata)) chk(1'b0, "R3 data moved while sclk high", sdata, p_sdata);
      if (!busy && sclk) chk(1'b0, "R4 sclk outside window", sclk, 0);
      if (strobe && sclk) chk(1'b0, "R4 sclk during strobe", sclk, 0);
      if (sclk && !p_sclk) begin
        chk(sdata == p_sdata, "R3 data stable at rise", sdata, p_sdata);
        chk(!strobe, "R6 strobe low while shifting", strobe, 0);
        if (rises > 0) chk(cyc - last_rise == 2*HD, "R5 sclk period", cyc - last_rise, 2*HD);
        chk(pload == 1'b0, "R1 pload during shift", pload, 0);
        dev_sreg = {dev_sreg[FW-2:0], sdata};
        rises++;
        last_rise = cyc;
      end
      if (strobe && !p_strobe) begin
        chk(rises == FW, "R4 rising edge count", rises, FW);
        chk(exp_q.size() > 0, "R8 unexpected frame", exp_q.size(), 1);
        if (exp_q.size() > 0) begin
          logic [FW-1:0] e;
          e = exp_q.pop_front();
          chk(dev_sreg == e, "R2 captured frame", dev_sreg, e);
        end
        strobe_rise = cyc;
      end
      if (!strobe && p_strobe) begin
        chk(cyc - strobe_rise == 2*HD, "R6 strobe width", cyc - strobe_rise, 2*HD);
        strobe_fall = cyc;
      end
      if (done) begin
        chk(cyc == strobe_fall + 1, "R7 done timing", cyc - strobe_fall, 1);
        chk(!busy, "R7 busy low with done", busy, 0);
        rises = 0;
        frames_done++;
      end
      if (done && p_done) chk(1'b0, "R7 done width", 2, 1);
    end
    p_sclk = sclk; p_strobe = strobe; p_sdata = sdata; p_done = done;
  end
  logic p_done = 0;

  // Driver: push the expected frame and issue a request.
  task automatic send(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
    while (busy) @(negedge clk);
    exp_q.push_back(expect_frame(t, n, m));
    req = 1'b1; test = t; div = n; mult = m;
    @(negedge clk);
    req = 1'b0;
    chk(busy, "R9 busy after accept", busy, 1);
    chk(!sclk && sdata == t[1], "R2 first bit before clock", sdata, t[1]);
  endtask

  task automatic wait_done();
    int n0;
    n0 = frames_done;
    while (frames_done == n0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!sclk && !strobe && !busy && !done, "R9 reset state", {sclk, strobe, busy, done}, 0);
    chk(pload == 1'b0, "R1 pload in reset", pload, 0);
    rst_n = 1'b1;
    @(negedge clk);

    send(2'b00, 2'b00, 9'h021); wait_done();   // R2 vector one
    send(2'b00, 2'b01, 9'h00C); wait_done();   // R2 vector two
    send(2'b11, 2'b11, 9'h1FF); wait_done();   // R2 null bit stays 0
    send(2'b01, 2'b10, 9'h0AA); wait_done();

    // R8: requests during a transfer are ignored
    send(2'b10, 2'b01, 9'h155);
    repeat (10) @(negedge clk);
    req = 1'b1; test = 2'b11; div = 2'b11; mult = 9'h0F0;
    repeat (3) @(negedge clk);
    req = 1'b0;
    wait_done();
    repeat (8 * HD * FW) @(negedge clk);
    chk(frames_done == 5, "R8 frame count", frames_done, 5);
    chk(exp_q.size() == 0, "R8 queue empty", exp_q.size(), 0);
    chk(!busy && !sclk && !strobe, "R4 idle after transfers", {busy, sclk, strobe}, 0);
    chk(pload == 1'b0, "R1 pload at end", pload, 0);
    finish_run();
  end
endmodule